// File: doc/BRIEF.md
# PLL Lock Indication Qualifier

This block turns the raw lock-detector output of a frequency synthesizer into a lock status that software and other logic can trust. The raw detector may toggle even while the loop is locked, so a single sample means little. The block first synchronizes the signal into the system clock domain. It then declares lock on a rising edge, or when the signal stays high for a programmed run of cycles. It declares loss of lock only when the signal stays low for that same programmed run. Each transition into lock raises a one-cycle interrupt pulse.

Waking the synthesizer from sleep can make the detector pin toggle. A wake pulse therefore opens a settling window of programmable length. During that window the status is held low, no interrupt is raised, and the run counters start again from zero.

A second, independent path checks the frequency-calibration result byte. It does this only when a result-valid strobe arrives. The reserved code 0x3F means the lock attempt failed, and any other code means success.

Top module: `pll_lock_qualifier`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `lock_status`, `lock_irq` and `cal_fail` are 0.
- R2: The raw input passes through a two-flop synchronizer. A 0-to-1 change of the synchronized detector outside the mask window sets `lock_status` three clock edges after `det_raw` is driven high.
- R3: When the synchronized detector has been high for `cfg_run_len` consecutive unmasked cycles, `lock_status` is set even though no rising edge was seen. A value of 0 acts as 1.
- R4: `lock_status` clears only after the synchronized detector has been low for `cfg_run_len` consecutive unmasked cycles. Low runs shorter than that, and toggling in between, leave it set.
- R5: `lock_irq` is a single-cycle pulse. It is raised in the same cycle that `lock_status` goes from 0 to 1, and never while the status was already 1.
- R6: A `wake_pulse` masks its own cycle and the following `cfg_wake_len` cycles. Masked cycles drive `lock_status` to 0 on the next edge, raise no `lock_irq`, ignore detector edges, and restart both run counts.
- R7: When `cal_valid` is 1, `cal_fail` is updated on the next edge: it is 1 if `cal_code` equals 0x3F and 0 for any other code. Without the strobe, `cal_fail` holds its value whatever `cal_code` carries.
- R8: The calibration path and the detector path act independently: a strobe in the same cycle as a lock event changes both outputs on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_raw | input | 1 | Raw lock-detector signal, asynchronous |
| wake_pulse | input | 1 | One-cycle wake-from-sleep indication |
| cfg_run_len | input | RUN_W (8) | Consecutive cycles for sustained high or low |
| cfg_wake_len | input | WAKE_W (12) | Length of the settling mask after a wake pulse |
| cal_valid | input | 1 | Calibration result strobe |
| cal_code | input | CAL_W (8) | Calibration result byte |
| lock_status | output | 1 | Qualified lock status |
| lock_irq | output | 1 | One-cycle pulse when lock is gained |
| cal_fail | output | 1 | Last strobed calibration result was the failure code |

## Verification
The functions most likely to collide are the wake-up mask and a rising edge of the synchronized detector. The bench raises the raw input two cycles before a wake pulse, so the synchronized edge lands exactly in the wake cycle. It then confirms three things: no interrupt and no status appear anywhere in the window, the edge is forgotten, and lock returns only through the sustained-high count after the window closes. A calibration strobe carrying the failure code is also placed in the cycle of a lock edge, and the bench checks that the interrupt and the failure flag rise on the same edge.

// File: rtl/lockq_pkg.sv
package lockq_pkg;

  typedef enum logic {
    ST_UNLOCKED = 1'b0,
    ST_LOCKED   = 1'b1
  } lock_state_e;

  // A run of 'cnt' samples already seen plus the current one reaches 'lim'.
  // A limit of zero behaves like one.
  function automatic logic run_reaches(input logic [31:0] cnt, input logic [31:0] lim);
    logic [32:0] next_len;
    next_len = {1'b0, cnt} + 33'd1;
    return next_len >= {1'b0, lim};
  endfunction

  // Saturating increment for a run counter of any width up to 32 bits.
  function automatic logic [31:0] sat_inc(input logic [31:0] cnt, input logic [31:0] top);
    return (cnt >= top) ? top : cnt + 32'd1;
  endfunction

  // Calibration verdict: only the reserved code means failure.
  function automatic logic code_is_fail(input logic [7:0] code, input logic [7:0] fail_code);
    return code == fail_code;
  endfunction

endpackage

// File: rtl/lockq_sync.sv
module lockq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/lockq_wake_mask.sv
module lockq_wake_mask #(
  parameter int WAKE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake_pulse,
  input  logic [WAKE_W-1:0] wake_len,
  output logic              masked
);

  logic [WAKE_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  remain_q <= '0;
    else if (wake_pulse)         remain_q <= wake_len;
    else if (remain_q != '0)     remain_q <= remain_q - 1'b1;
  end

  assign masked = wake_pulse | (remain_q != '0);

  // R6
  wake_opens_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pulse && wake_len != '0) |=> masked);

  // R6
  window_counts_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (masked && !wake_pulse && remain_q != '0) |=> (remain_q == $past(remain_q) - 1'b1) || wake_pulse);

endmodule

// File: rtl/lockq_run_ctr.sv
module lockq_run_ctr
  import lockq_pkg::*;
#(
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             level,
  input  logic [RUN_W-1:0] limit,
  output logic             reached
);

  localparam logic [31:0] CNT_TOP = 32'((64'd1 << RUN_W) - 64'd1);

  logic [RUN_W-1:0] run_q;
  logic [31:0]      run_next;

  assign run_next = sat_inc(32'(run_q), CNT_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_q <= '0;
    else if (restart || !level) run_q <= '0;
    else                        run_q <= run_next[RUN_W-1:0];
  end

  assign reached = level && !restart && run_reaches(32'(run_q), 32'(limit));

  // R4
  run_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart || !level) |=> (run_q == '0));

endmodule

// File: rtl/lockq_lock_fsm.sv
module lockq_lock_fsm
  import lockq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic det_s,
  input  logic masked,
  input  logic high_hit,
  input  logic low_hit,
  output logic lock_status,
  output logic lock_irq
);

  lock_state_e state_q;
  logic        det_prev_q;
  logic        rise;
  logic        gain;

  assign rise = det_s & ~det_prev_q;
  assign gain = !masked && det_s && (rise || high_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_UNLOCKED;
      lock_irq   <= 1'b0;
      det_prev_q <= 1'b0;
    end else begin
      det_prev_q <= det_s;
      lock_irq   <= 1'b0;
      if (masked) begin
        state_q <= ST_UNLOCKED;
      end else if (gain) begin
        state_q  <= ST_LOCKED;
        lock_irq <= (state_q == ST_UNLOCKED);
      end else if (low_hit) begin
        state_q <= ST_UNLOCKED;
      end
    end
  end

  assign lock_status = (state_q == ST_LOCKED);

  // R5
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_irq |=> !lock_irq);

  // R5
  irq_on_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_irq |-> (lock_status && !$past(lock_status)));

  // R6
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    masked |=> (!lock_status && !lock_irq));

  // R2
  edge_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !masked) |=> lock_status);

  // R4
  drop_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_status) |-> ($past(masked) || !$past(det_s)));

endmodule

// File: rtl/lockq_cal_check.sv
module lockq_cal_check
  import lockq_pkg::*;
#(
  parameter int             CAL_W     = 8,
  parameter logic [CAL_W-1:0] FAIL_CODE = 8'h3F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_valid,
  input  logic [CAL_W-1:0] cal_code,
  output logic             cal_fail
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cal_fail <= 1'b0;
    else if (cal_valid) cal_fail <= code_is_fail(8'(cal_code), 8'(FAIL_CODE));
  end

  // R7
  cal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_valid |=> $stable(cal_fail));

  // R7
  cal_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_valid |=> (cal_fail == ($past(cal_code) == FAIL_CODE)));

endmodule

// File: rtl/pll_lock_qualifier.sv
module pll_lock_qualifier #(
  parameter int RUN_W       = 8,
  parameter int WAKE_W      = 12,
  parameter int CAL_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det_raw,
  input  logic              wake_pulse,
  input  logic [RUN_W-1:0]  cfg_run_len,
  input  logic [WAKE_W-1:0] cfg_wake_len,
  input  logic              cal_valid,
  input  logic [CAL_W-1:0]  cal_code,
  output logic              lock_status,
  output logic              lock_irq,
  output logic              cal_fail
);

  localparam int N_RUNS = 2;   // index 0: high run, index 1: low run

  logic              det_s;
  logic              masked;
  logic [N_RUNS-1:0] run_hit;

  lockq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (det_raw),
    .q_sync  (det_s)
  );

  lockq_wake_mask #(.WAKE_W(WAKE_W)) u_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .wake_pulse (wake_pulse),
    .wake_len   (cfg_wake_len),
    .masked     (masked)
  );

  generate
    for (genvar g = 0; g < N_RUNS; g++) begin : g_run
      lockq_run_ctr #(.RUN_W(RUN_W)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (masked),
        .level   ((g == 0) ? det_s : ~det_s),
        .limit   (cfg_run_len),
        .reached (run_hit[g])
      );
    end
  endgenerate

  lockq_lock_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .det_s       (det_s),
    .masked      (masked),
    .high_hit    (run_hit[0]),
    .low_hit     (run_hit[1]),
    .lock_status (lock_status),
    .lock_irq    (lock_irq)
  );

  lockq_cal_check #(.CAL_W(CAL_W), .FAIL_CODE(CAL_W'(8'h3F))) u_cal (
    .clk       (clk),
    .rst_n     (rst_n),
    .cal_valid (cal_valid),
    .cal_code  (cal_code),
    .cal_fail  (cal_fail)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!lock_status && !lock_irq && !cal_fail));

endmodule

// File: tb/pll_lock_qualifier_test.sv
`timescale 1ns/1ps
module pll_lock_qualifier_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        det_raw = 1'b0;
  logic        wake_pulse = 1'b0;
  logic [7:0]  cfg_run_len = 8'd3;
  logic [11:0] cfg_wake_len = 12'd4;
  logic        cal_valid = 1'b0;
  logic [7:0]  cal_code = 8'h00;
  logic        lock_status, lock_irq, cal_fail;

  int nerr = 0;
  int nchk = 0;

  always #2.5 clk = ~clk;

  pll_lock_qualifier uut (
    .clk(clk), .rst_n(rst_n), .det_raw(det_raw), .wake_pulse(wake_pulse),
    .cfg_run_len(cfg_run_len), .cfg_wake_len(cfg_wake_len),
    .cal_valid(cal_valid), .cal_code(cal_code),
    .lock_status(lock_status), .lock_irq(lock_irq), .cal_fail(cal_fail)
  );

  // {raw, wake, cal_valid, cal_code[7:0], exp_status, exp_irq, exp_fail}
  // Expected fields are the outputs seen before this row's inputs take effect.
  typedef logic [13:0] vec_t;
  localparam vec_t TBL [16] = '{
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},  // R1 reset state
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},  // glitch low
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0},  // R2 lock from edge
    {1'b0, 1'b0, 1'b1, 8'h3F, 1'b1, 1'b0, 1'b0},  // R7 fail code
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1},  // R5 re-edge, no irq
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1},
    {1'b0, 1'b0, 1'b1, 8'h40, 1'b1, 1'b0, 1'b1},
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},  // R4 cleared after 3 lows
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'h3F, 1'b0, 1'b0, 1'b0},  // R7 code without strobe
    {1'b1, 1'b0, 1'b1, 8'h3F, 1'b0, 1'b0, 1'b0},  // R8 strobe with edge
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1},
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1}
  };

  task automatic check(input string tag, input logic got, input logic exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input logic raw, input logic wk, input logic cv, input logic [7:0] code);
    @(negedge clk);
    det_raw    = raw;
    wake_pulse = wk;
    cal_valid  = cv;
    cal_code   = code;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    check("R1 status in reset", lock_status, 1'b0);
    check("R1 irq in reset", lock_irq, 1'b0);
    check("R1 fail in reset", cal_fail, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // Vector walk
    for (int i = 0; i < 16; i++) begin
      vec_t v;
      v = TBL[i];
      @(negedge clk);
      check($sformatf("R2/R4 status row %0d", i), lock_status, v[2]);
      check($sformatf("R5 irq row %0d", i), lock_irq, v[1]);
      check($sformatf("R7 fail row %0d", i), cal_fail, v[0]);
      det_raw    = v[13];
      wake_pulse = v[12];
      cal_valid  = v[11];
      cal_code   = v[10:3];
    end

    // R6 + R3: wake while locked and steady high; relock only by sustained high
    step(1'b1, 1'b1, 1'b0, 8'h00);
    check("R6 status before wake takes effect", lock_status, 1'b1);
    for (int k = 1; k <= 7; k++) begin
      step(1'b1, 1'b0, 1'b0, 8'h00);
      check($sformatf("R6 status in window k=%0d", k), lock_status, 1'b0);
      check($sformatf("R6 irq in window k=%0d", k), lock_irq, 1'b0);
    end
    step(1'b1, 1'b0, 1'b0, 8'h00);
    check("R3 sustained high relock status", lock_status, 1'b1);
    check("R3 sustained high relock irq", lock_irq, 1'b1);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    check("R5 irq one cycle", lock_irq, 1'b0);

    // R4: long low clears
    for (int k = 0; k < 6; k++) step(1'b0, 1'b0, 1'b0, 8'h00);
    check("R4 cleared after low run", lock_status, 1'b0);

    // R6: synchronized rising edge lands in the wake cycle
    step(1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b1, 1'b1, 1'b0, 8'h00);
    for (int k = 1; k <= 7; k++) begin
      step(1'b1, 1'b0, 1'b0, 8'h00);
      check($sformatf("R6 edge in wake ignored irq k=%0d", k), lock_irq, 1'b0);
      check($sformatf("R6 edge in wake ignored status k=%0d", k), lock_status, 1'b0);
    end
    step(1'b1, 1'b0, 1'b0, 8'h00);
    check("R3 lock after window status", lock_status, 1'b1);
    check("R3 lock after window irq", lock_irq, 1'b1);

    // R4/R5: toggling with low runs of two keeps lock, no new irq
    for (int k = 0; k < 12; k++) begin
      step((k % 3) == 2, 1'b0, 1'b0, 8'h00);
      check($sformatf("R4 toggling keeps lock k=%0d", k), lock_status, 1'b1);
      check($sformatf("R5 no irq while locked k=%0d", k), lock_irq, 1'b0);
    end

    // R7: fail code then a good code, with no strobe in between
    step(1'b1, 1'b0, 1'b1, 8'h3F);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    check("R7 fail set", cal_fail, 1'b1);
    step(1'b1, 1'b0, 1'b0, 8'h3E);
    check("R7 held without strobe", cal_fail, 1'b1);
    step(1'b1, 1'b0, 1'b1, 8'h3E);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    check("R7 good code clears", cal_fail, 1'b0);

    // R1: reset in the middle of operation
    step(1'b1, 1'b0, 1'b1, 8'h3F);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 status after mid reset", lock_status, 1'b0);
    check("R1 irq after mid reset", lock_irq, 1'b0);
    check("R1 fail after mid reset", cal_fail, 1'b0);

    summary();
    $finish;
  end

endmodule